// File: doc/BRIEF.md
# Master-Clock Ratio Detector

This block works out, once after reset, how fast the master clock runs compared with the audio sample rate. It counts master-clock cycles between rising edges of the word-select signal and sorts each count into one of three ratios: 256, 384 or 512 times the sample rate. Word select is asynchronous to the block, so it is resynchronised before any edge is taken from it.

When two measurements in a row fall into the same ratio class, the block declares lock and freezes the ratio code until the next reset. It also loads a bit-rate divider for a frame of 64 bit clocks, which is a divide by 4, 6 or 8 of the master clock. From then on the block drives a one-cycle enable pulse train, phased so that a pulse falls in each cycle where a word-select rising edge is seen. If measurements keep failing, a sticky error flag tells the system that no supported ratio is present.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, `locked`, `error` and `bitEn` are 0 and `ratioCode` is 2'b00.
- R2: Word select passes through two synchronising flops. Only its rising edges start or end a measurement, and where the falling edge lies within the period has no effect.
- R3: A measured count within 4 cycles of 256, 384 or 512 is classified as code 2'b00, 2'b01 or 2'b10. The code 2'b11 never appears.
- R4: `locked` rises in the cycle after a rising edge whose measurement falls in the same class as the measurement just before it. `ratioCode` takes that class at the same moment.
- R5: A measurement outside every tolerance window drops any pending candidate class and counts as one failed attempt.
- R6: The eighth failed attempt sets `error`. `error` then stays high until reset, and `locked` never rises while it is high.
- R7: During measurement, if no rising edge arrives for 1022 cycles after the last one, that counts as a failed attempt and the counter restarts.
- R8: Once locked, `locked` and `ratioCode` stay constant until reset, whatever word select does.
- R9: While locked, `bitEn` is a one-cycle pulse every 4, 6 or 8 cycles for codes 2'b00, 2'b01 or 2'b10. It is 0 while not locked.
- R10: The divider phase is set at lock, so that while word select keeps the locked period, `bitEn` is high in every cycle in which a synchronised rising edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rstMclk | input | 1 | Synchronous active-high reset |
| lrckIn | input | 1 | Asynchronous word-select input at the sample rate |
| ratioCode | output | 2 | Detected ratio: 00 = 256, 01 = 384, 10 = 512 |
| locked | output | 1 | Ratio detected and frozen |
| error | output | 1 | Eight failed measurements; sticky until reset |
| bitEn | output | 1 | One-cycle bit-rate enable pulse |

## Verification
Clean periods of 256, 384 and 512 cycles show that each class gets its own code and its own divider length. Periods at the edges of the tolerance windows (252, 516) test the acceptance limits, and a period of 250 must be rejected every time until the error flag rises. Periods alternating between two valid ratios show that lock needs two matching measurements in a row, not just two valid ones. An out-of-range period placed between valid ones shows that the candidate is dropped. A word select that stops toggling exercises the timeout path. A change of period after lock, and a very short high phase, show that the frozen code and the falling edge have no effect.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS = 3;
  localparam int RATIO_UNIT = 128;
  localparam int BITS_PER_FRAME = 64;

  typedef struct packed {
    logic cntClear;
    logic candLoad;
    logic candClear;
    logic failInc;
    logic lockSet;
  } ctrlStrobe_t;

  function automatic int nominalOf(input int idx);
    return RATIO_UNIT * (idx + 2);
  endfunction

  function automatic int divOf(input int idx);
    return nominalOf(idx) / BITS_PER_FRAME;
  endfunction
endpackage

// File: rtl/mrd_datapath.sv
module mrd_datapath
  import mrd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL = 4,
  parameter int MAX_FAILS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lrckIn,
  input  ctrlStrobe_t strb,
  input  logic        locked,
  output logic        rise,
  output logic        timeout,
  output logic        measValid,
  output logic        candMatch,
  output logic        lastFail,
  output logic [1:0]  ratioCode,
  output logic        bitEn
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int FAIL_W = $clog2(MAX_FAILS + 1);
  localparam int DIV_W = $clog2(divOf(NUM_RATIOS - 1));

  logic syncA, syncB, syncC;
  logic [CNT_W-1:0] cnt;
  logic [NUM_RATIOS-1:0] hit;
  logic [1:0] measClass, candQ, codeQ;
  logic candValid;
  logic [FAIL_W-1:0] failCnt;
  logic [DIV_W-1:0] divCnt, divLast;

  // two-flop synchroniser plus edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= lrckIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end
  assign rise = syncB & ~syncC;

  // period counter, saturating
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (strb.cntClear) cnt <= CNT_W'(1);
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
  assign timeout = (cnt == CNT_MAX);

  // tolerance windows, one per supported ratio
  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
    localparam int LO = nominalOf(g) - TOL;
    localparam int HI = nominalOf(g) + TOL;
    assign hit[g] = (int'(cnt) >= LO) && (int'(cnt) <= HI);
  end

  always_comb begin
    measClass = 2'b00;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) measClass = 2'(i);
    end
  end
  assign measValid = |hit;

  // candidate class from the previous measurement
  always_ff @(posedge clk) begin
    if (rst) begin
      candQ <= 2'b00;
      candValid <= 1'b0;
    end else if (strb.candLoad) begin
      candQ <= measClass;
      candValid <= 1'b1;
    end else if (strb.candClear) begin
      candValid <= 1'b0;
    end
  end
  assign candMatch = candValid && (candQ == measClass) && measValid;

  // failed attempt counter
  always_ff @(posedge clk) begin
    if (rst) failCnt <= '0;
    else if (strb.failInc && !lastFail) failCnt <= failCnt + 1'b1;
  end
  assign lastFail = (failCnt == FAIL_W'(MAX_FAILS - 1));

  // frozen ratio code
  always_ff @(posedge clk) begin
    if (rst) codeQ <= 2'b00;
    else if (strb.lockSet) codeQ <= measClass;
  end
  assign ratioCode = codeQ;

  // bit-rate divider
  always_comb begin
    divLast = DIV_W'(divOf(0) - 1);
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (codeQ == 2'(i)) divLast = DIV_W'(divOf(i) - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else if (strb.lockSet) divCnt <= DIV_W'(1);
    else if (locked) divCnt <= (divCnt == divLast) ? '0 : divCnt + 1'b1;
  end
  assign bitEn = locked && (divCnt == '0);

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst) ratioCode != 2'b11); // R3
  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (rst) $onehot0(hit)); // R3
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst) locked |=> $stable(ratioCode)); // R8
  AST_EN_GATED: assert property (@(posedge clk) disable iff (rst) bitEn |-> locked); // R9
  AST_EN_SPACED: assert property (@(posedge clk) disable iff (rst) bitEn |=> !bitEn); // R9
  AST_FAIL_BOUND: assert property (@(posedge clk) disable iff (rst) int'(failCnt) < MAX_FAILS); // R6
endmodule

// File: rtl/mrd_control.sv
module mrd_control
  import mrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rise,
  input  logic        timeout,
  input  logic        measValid,
  input  logic        candMatch,
  input  logic        lastFail,
  output ctrlStrobe_t strb,
  output logic        locked,
  output logic        error
);
  typedef enum logic [1:0] {ST_WAIT, ST_MEAS, ST_LOCK, ST_FAULT} state_e;
  state_e state, stateNext;

  always_comb begin
    strb = '0;
    stateNext = state;
    unique case (state)
      ST_WAIT: begin
        if (rise) begin
          strb.cntClear = 1'b1;
          stateNext = ST_MEAS;
        end
      end
      ST_MEAS: begin
        if (rise || timeout) begin
          strb.cntClear = 1'b1;
          if (rise && measValid) begin
            if (candMatch) begin
              strb.lockSet = 1'b1;
              stateNext = ST_LOCK;
            end else begin
              strb.candLoad = 1'b1;
            end
          end else begin
            strb.candClear = 1'b1;
            strb.failInc = 1'b1;
            if (lastFail) stateNext = ST_FAULT;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT;
    else state <= stateNext;
  end

  assign locked = (state == ST_LOCK);
  assign error = (state == ST_FAULT);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) error |=> error); // R6
  AST_LOCK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(locked && error)); // R6
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst) locked |=> locked); // R8
  AST_LOCK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> $past(rise)); // R4
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL = 4,
  parameter int MAX_FAILS = 8
) (
  input  logic       mclk,
  input  logic       rstMclk,
  input  logic       lrckIn,
  output logic [1:0] ratioCode,
  output logic       locked,
  output logic       error,
  output logic       bitEn
);
  ctrlStrobe_t strb;
  logic rise, timeout, measValid, candMatch, lastFail;

  mrd_datapath #(.CNT_W(CNT_W), .TOL(TOL), .MAX_FAILS(MAX_FAILS)) uDatapath (
    .clk(mclk), .rst(rstMclk), .lrckIn(lrckIn), .strb(strb), .locked(locked),
    .rise(rise), .timeout(timeout), .measValid(measValid), .candMatch(candMatch),
    .lastFail(lastFail), .ratioCode(ratioCode), .bitEn(bitEn)
  );

  mrd_control uControl (
    .clk(mclk), .rst(rstMclk), .rise(rise), .timeout(timeout), .measValid(measValid),
    .candMatch(candMatch), .lastFail(lastFail), .strb(strb), .locked(locked), .error(error)
  );
endmodule

// File: tb/tb_mclk_ratio_detect.sv
`timescale 1ns/1ps
module tb_mclk_ratio_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lrck = 1'b0;
  logic [1:0] ratioCode;
  logic locked, error, bitEn;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mclk_ratio_detect dut (
    .mclk(clk), .rstMclk(rst), .lrckIn(lrck),
    .ratioCode(ratioCode), .locked(locked), .error(error), .bitEn(bitEn)
  );

  // behavioural reference
  int mState, mCnt, mCand, mFails, mCode, mPhase;
  bit q1, q2, q3;
  bit mRise, mTout;
  int mCls, nCnt, nState;

  function automatic int classify(input int c);
    for (int i = 0; i < 3; i++)
      if (c >= 128 * (i + 2) - 4 && c <= 128 * (i + 2) + 4) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mState = 0; mCnt = 0; mCand = -1; mFails = 0; mCode = 0; mPhase = 0;
      q1 = 0; q2 = 0; q3 = 0;
    end else begin
      mRise = q2 && !q3;
      mTout = (mCnt == 1023);
      mCls = classify(mCnt);
      nCnt = (mCnt == 1023) ? 1023 : mCnt + 1;
      nState = mState;
      if (mState == 2) mPhase = (mPhase + 1) % (2 * (mCode + 2));
      if (mState == 0) begin
        if (mRise) begin nCnt = 1; nState = 1; end
      end else if (mState == 1) begin
        if (mRise || mTout) begin
          nCnt = 1;
          if (mRise && mCls >= 0) begin
            if (mCand == mCls) begin nState = 2; mCode = mCls; mPhase = 1; end
            else mCand = mCls;
          end else begin
            mCand = -1;
            mFails++;
            if (mFails == 8) nState = 3;
          end
        end
      end
      mCnt = nCnt; mState = nState;
      q3 = q2; q2 = q1; q1 = lrck;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    check("R4 locked", int'(locked), (mState == 2) ? 1 : 0);
    check("R6 error", int'(error), (mState == 3) ? 1 : 0);
    check("R3/R8 ratioCode", int'(ratioCode), mCode);
    check("R9/R10 bitEn", int'(bitEn), (mState == 2 && mPhase == 0) ? 1 : 0);
  end

  task automatic doReset();
    rst = 1'b1;
    lrck = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 locked in reset", int'(locked), 0);
    check("R1 error in reset", int'(error), 0);
    check("R1 code in reset", int'(ratioCode), 0);
    check("R1 bitEn in reset", int'(bitEn), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 locked after reset", int'(locked), 0);
  endtask

  task automatic runPeriods(input int p, input int n, input int hi);
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < p; c++) begin
        lrck = (c < hi);
        @(negedge clk);
      end
    end
  endtask

  task automatic holdLow(input int n);
    lrck = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  int enSeen;

  initial begin
    doReset();
    runPeriods(256, 5, 128);
    check("R4 lock at 256", int'(locked), 1);
    check("R3 code 256", int'(ratioCode), 0);
    enSeen = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      enSeen += int'(bitEn);
    end
    check("R9 pulses per 64 cycles at 256", enSeen, 16);

    doReset();
    runPeriods(384, 5, 192);
    check("R3 code 384", int'(ratioCode), 1);

    doReset();
    runPeriods(512, 5, 256);
    check("R3 code 512", int'(ratioCode), 2);
    enSeen = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      enSeen += int'(bitEn);
    end
    check("R9 pulses per 64 cycles at 512", enSeen, 8);

    doReset();
    runPeriods(252, 5, 126);
    check("R3 lower window edge", int'(locked), 1);
    doReset();
    runPeriods(516, 5, 258);
    check("R3 upper window edge code", int'(ratioCode), 2);

    doReset();
    runPeriods(256, 5, 10);
    check("R2 short high phase still locks", int'(locked), 1);

    doReset();
    runPeriods(250, 11, 125);
    check("R6 error after out-of-range periods", int'(error), 1);
    check("R6 no lock with error", int'(locked), 0);

    doReset();
    runPeriods(256, 1, 128);
    runPeriods(250, 1, 125);
    runPeriods(256, 1, 128);
    runPeriods(256, 1, 128);
    holdLow(200);
    check("R5 candidate dropped by bad period", int'(locked), 0);
    check("R5 single failure no error", int'(error), 0);

    doReset();
    for (int k = 0; k < 4; k++) begin
      runPeriods(256, 1, 128);
      runPeriods(384, 1, 192);
    end
    check("R4 alternating classes never lock", int'(locked), 0);
    runPeriods(384, 2, 192);
    check("R4 lock after matching pair", int'(locked), 1);
    check("R4 code after matching pair", int'(ratioCode), 1);

    doReset();
    runPeriods(256, 2, 128);
    holdLow(7000);
    check("R7 seven timeouts no error yet", int'(error), 0);
    holdLow(2000);
    check("R7 timeouts raise error", int'(error), 1);

    doReset();
    runPeriods(256, 4, 128);
    runPeriods(512, 4, 256);
    runPeriods(384, 3, 50);
    check("R8 code frozen after lock", int'(ratioCode), 0);
    check("R8 locked held", int'(locked), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule